// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop is locked. It watches the two divider outputs of the loop: the divided reference and the divided feedback. It measures how far apart their rising edges are by counting cycles of a fast sampling clock. The measured error is compared against a lock window. A single comparison is not enough to judge lock. Only one measurement in every `DECIM` is used, and the rest are discarded. Lock is declared after `LOCK_N` sampled comparisons in a row fall inside the window. One sampled comparison outside the window removes lock straight away.

Both divider inputs are resynchronised into the sampling-clock domain, and their rising edges are extracted there. The phase meter is a state machine. It stays in `MS_IDLE` until an edge arrives. From there it moves to `MS_REF_LEAD` or `MS_FB_LEAD`, depending on which edge came first, and counts ticks until the other edge arrives. If the count runs out at `WIN_TICKS+1`, the meter reports an out-of-window result. It then parks in `MS_DRAIN_FB` or `MS_DRAIN_REF` until the late edge has passed. If the leading signal pulses again while draining, a new measurement starts.

The lock machine has two states, `LK_SEEK` and `LK_HELD`. The transition `LK_SEEK -> LK_HELD` happens on the `LOCK_N`-th consecutive good sampled result. The transition `LK_HELD -> LK_SEEK` happens on any bad sampled result. The output `lock_out` shows `LK_HELD` only while `ld_enable` and `chip_en` are both high. Pulling `chip_en` low works as power-down and clears every counter and state.

Top module: `pll_lock_detect`

## Requirements
- R1: The phase error is the number of sampling-clock ticks between the synchronised rising edges of `ref_in` and `fb_in`, in either order. Edges in the same tick give an error of 0. Each reference/feedback pulse pair yields exactly one measurement.
- R2: A measurement is good when its error is at most `WIN_TICKS` (default 4). It is bad when the error is `WIN_TICKS+1` or more, and also when the second edge has not arrived by then.
- R3: Only the `DECIM`-th measurement (default 64) counted since reset or power-up is evaluated, then every `DECIM`-th after it. All other measurements have no effect on lock state.
- R4: `lock_out` rises only after `LOCK_N` (default 4) consecutive evaluated measurements are good.
- R5: While locked, one evaluated bad measurement returns the machine to `LK_SEEK` and drives `lock_out` low.
- R6: An evaluated bad measurement clears the consecutive-good count. The count saturates at `LOCK_N` and never wraps.
- R7: With `ld_enable` = 0, `lock_out` is 0 at all times. The lock state is not disturbed, so `lock_out` shows it again once `ld_enable` returns to 1.
- R8: With `chip_en` = 0, `lock_out` is 0 at once, and the lock state, the good count and the measurement count are all cleared. Counting restarts from zero when `chip_en` returns high.
- R9: The synchronous active-high `rst` clears all state and counters, and `lock_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Power enable; low holds the detector unlocked |
| ld_enable | input | 1 | Output mode; 0 forces `lock_out` low |
| ref_in | input | 1 | Divided reference pulse, asynchronous |
| fb_in | input | 1 | Divided feedback pulse, asynchronous |
| lock_out | output | 1 | Lock indication |

## Verification
Some behaviours are checked by assertions on every cycle:
- the meter's tick count stays inside its range;
- a timeout produces a bad result;
- coincident edges produce a good result;
- the good count saturates;
- the lock state cannot change between evaluated measurements;
- power-down clears the state.

Other behaviours need the bench's scenarios:
- the exact evaluation point;
- the window boundary at `WIN_TICKS` against `WIN_TICKS+1`, in both edge orders;
- recovery of the good count after a bad sample;
- the masking done by `ld_enable`.

These depend on counting whole pulse pairs from reset.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_REF_LEAD,
        MS_FB_LEAD,
        MS_DRAIN_FB,
        MS_DRAIN_REF
    } meas_state_t;

    typedef enum logic {
        LK_SEEK,
        LK_HELD
    } lock_state_t;

endpackage

// File: rtl/ld_edge_sync.sv
module ld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ld_phase_meter.sv
module ld_phase_meter
    import pll_ld_pkg::*;
#(
    parameter int WIN_TICKS = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic ref_edge,
    input  logic fb_edge,
    output logic meas_valid,
    output logic meas_good
);
    localparam int LIMIT = WIN_TICKS + 1;
    localparam int CW    = $clog2(LIMIT + 1);

    meas_state_t     st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            valid_d, good_d;
    logic            valid_q, good_q;

    // next-state and result logic
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        valid_d = 1'b0;
        good_d  = 1'b0;
        unique case (st_q)
            MS_IDLE: begin
                if (ref_edge && fb_edge) begin
                    valid_d = 1'b1;
                    good_d  = 1'b1;
                end else if (ref_edge) begin
                    st_d  = MS_REF_LEAD;
                    cnt_d = CW'(1);
                end else if (fb_edge) begin
                    st_d  = MS_FB_LEAD;
                    cnt_d = CW'(1);
                end
            end
            MS_REF_LEAD: begin
                if (fb_edge) begin
                    valid_d = 1'b1;
                    good_d  = (cnt_q <= CW'(WIN_TICKS));
                    st_d    = MS_IDLE;
                end else if (cnt_q == CW'(LIMIT)) begin
                    valid_d = 1'b1;
                    st_d    = MS_DRAIN_FB;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            MS_FB_LEAD: begin
                if (ref_edge) begin
                    valid_d = 1'b1;
                    good_d  = (cnt_q <= CW'(WIN_TICKS));
                    st_d    = MS_IDLE;
                end else if (cnt_q == CW'(LIMIT)) begin
                    valid_d = 1'b1;
                    st_d    = MS_DRAIN_REF;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            MS_DRAIN_FB: begin
                if (fb_edge) begin
                    st_d = MS_IDLE;
                end else if (ref_edge) begin
                    st_d  = MS_REF_LEAD;
                    cnt_d = CW'(1);
                end
            end
            MS_DRAIN_REF: begin
                if (ref_edge) begin
                    st_d = MS_IDLE;
                end else if (fb_edge) begin
                    st_d  = MS_FB_LEAD;
                    cnt_d = CW'(1);
                end
            end
            default: st_d = MS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (clr) begin
            st_q  <= MS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (clr) begin
            valid_q <= 1'b0;
            good_q  <= 1'b0;
        end else begin
            valid_q <= valid_d;
            good_q  <= good_d;
        end
    end

    assign meas_valid = valid_q;
    assign meas_good  = good_q;

    p_count_range_r2: assert property (@(posedge clk) disable iff (clr)
        (st_q == MS_REF_LEAD || st_q == MS_FB_LEAD)
            |-> (cnt_q >= CW'(1) && cnt_q <= CW'(LIMIT)));

    p_timeout_bad_r2: assert property (@(posedge clk) disable iff (clr)
        (st_q == MS_REF_LEAD && cnt_q == CW'(LIMIT) && !fb_edge)
            |=> (meas_valid && !meas_good));

    p_coincident_good_r1: assert property (@(posedge clk) disable iff (clr)
        (st_q == MS_IDLE && ref_edge && fb_edge) |=> (meas_valid && meas_good));

endmodule

// File: rtl/ld_lock_fsm.sv
module ld_lock_fsm
    import pll_ld_pkg::*;
#(
    parameter int DECIM  = 64,
    parameter int LOCK_N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic chip_en,
    input  logic meas_valid,
    input  logic meas_good,
    output logic locked
);
    localparam int DW = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int GW = $clog2(LOCK_N + 1);

    lock_state_t     st_q, st_d;
    logic [DW-1:0]   decim_q, decim_d;
    logic [GW-1:0]   run_q, run_d;
    logic            sample_fire;

    assign sample_fire = meas_valid && (decim_q == DW'(DECIM - 1));

    // next-state logic
    always_comb begin
        st_d    = st_q;
        run_d   = run_q;
        decim_d = decim_q;
        if (meas_valid)
            decim_d = (decim_q == DW'(DECIM - 1)) ? '0 : decim_q + DW'(1);
        if (sample_fire) begin
            if (!meas_good)
                run_d = '0;
            else if (run_q != GW'(LOCK_N))
                run_d = run_q + GW'(1);
        end
        unique case (st_q)
            LK_SEEK: if (sample_fire && meas_good && run_q == GW'(LOCK_N - 1))
                         st_d = LK_HELD;
            LK_HELD: if (sample_fire && !meas_good)
                         st_d = LK_SEEK;
            default: st_d = LK_SEEK;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst || !chip_en) begin
            st_q    <= LK_SEEK;
            run_q   <= '0;
            decim_q <= '0;
        end else begin
            st_q    <= st_d;
            run_q   <= run_d;
            decim_q <= decim_d;
        end
    end

    // outputs
    always_comb begin
        locked = (st_q == LK_HELD);
    end

    p_drop_on_bad_r5: assert property (@(posedge clk) disable iff (rst)
        (chip_en && sample_fire && !meas_good) |=> (st_q == LK_SEEK && run_q == '0));

    p_hold_between_samples_r3: assert property (@(posedge clk) disable iff (rst)
        (chip_en && !sample_fire && st_q == LK_HELD) |=> (st_q == LK_HELD));

    p_rise_after_run_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == LK_HELD) |-> ($past(run_q) == GW'(LOCK_N - 1) && $past(sample_fire)));

    p_run_saturates_r6: assert property (@(posedge clk) disable iff (rst)
        run_q <= GW'(LOCK_N));

    p_powerdown_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> (st_q == LK_SEEK && run_q == '0 && decim_q == '0));

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
    parameter int WIN_TICKS   = 4,
    parameter int DECIM       = 64,
    parameter int LOCK_N      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic chip_en,
    input  logic ld_enable,
    input  logic ref_in,
    input  logic fb_in,
    output logic lock_out
);
    logic ref_rise, fb_rise;
    logic meas_valid, meas_good;
    logic locked;
    logic meter_clr;

    assign meter_clr = rst | ~chip_en;

    ld_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_in),
        .rise     (ref_rise)
    );

    ld_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (fb_in),
        .rise     (fb_rise)
    );

    ld_phase_meter #(.WIN_TICKS(WIN_TICKS)) u_meter (
        .clk        (clk),
        .clr        (meter_clr),
        .ref_edge   (ref_rise),
        .fb_edge    (fb_rise),
        .meas_valid (meas_valid),
        .meas_good  (meas_good)
    );

    ld_lock_fsm #(.DECIM(DECIM), .LOCK_N(LOCK_N)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .chip_en    (chip_en),
        .meas_valid (meas_valid),
        .meas_good  (meas_good),
        .locked     (locked)
    );

    assign lock_out = locked & ld_enable & chip_en;

endmodule

// File: tb/pll_lock_detect_bench.sv
module pll_lock_detect_bench;
    localparam int DECIM  = 64;
    localparam int LOCK_N = 4;
    localparam int PERIOD = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_en = 1'b1;
    logic ld_enable = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic lock_out;

    int total = 0;
    int bad = 0;
    int meas_idx = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pll_lock_detect u_pll_lock_detect (
        .clk       (clk),
        .rst       (rst),
        .chip_en   (chip_en),
        .ld_enable (ld_enable),
        .ref_in    (ref_in),
        .fb_in     (fb_in),
        .lock_out  (lock_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input logic exp, input string req);
        @(negedge clk);
        total = total + 1;
        if (lock_out !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: lock_out actual=%b expected=%b", req, lock_out, exp);
        end
    endtask

    // one pulse pair; gap >= 0: ref leads by gap ticks, gap < 0: fb leads
    task automatic pair(input int gap);
        int ra, fa;
        ra = (gap < 0) ? 2 - gap : 2;
        fa = (gap < 0) ? 2 : 2 + gap;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            ref_in = (i >= ra && i < ra + 3);
            fb_in  = (i >= fa && i < fa + 3);
        end
        @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        meas_idx = meas_idx + 1;
    endtask

    // gap_s on evaluated (every DECIM-th) measurement, gap_o on the rest
    task automatic feed(input int n, input int gap_s, input int gap_o);
        for (int k = 0; k < n; k++) begin
            if ((meas_idx % DECIM) == DECIM - 1) pair(gap_s);
            else                                  pair(gap_o);
        end
    endtask

    task automatic to_sample(input int gap_o);
        while ((meas_idx % DECIM) != DECIM - 1) pair(gap_o);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        meas_idx = 0;
        check(1'b0, "R9 reset");
    endtask

    task automatic t_acquire;
        feed(3 * DECIM, 1, 8);
        check(1'b0, "R4 three good samples");
        feed(DECIM - 1, 1, 8);
        check(1'b0, "R4 before fourth sample");
        feed(1, 1, 8);
        check(1'b1, "R4 fourth good sample, R3 bad others ignored");
    endtask

    task automatic t_enable;
        ld_enable = 1'b0;
        check(1'b0, "R7 disabled output");
        feed(10, 1, 1);
        check(1'b0, "R7 disabled while pulses run");
        ld_enable = 1'b1;
        check(1'b1, "R7 state kept");
    endtask

    task automatic t_drop;
        to_sample(8);
        check(1'b1, "R3 unsampled bad ignored");
        feed(1, 6, 8);
        check(1'b0, "R5 one bad sample drops lock");
    endtask

    task automatic t_run_clear;
        feed(3 * DECIM, 1, 8);
        check(1'b0, "R6 three good");
        feed(DECIM, 7, 1);
        check(1'b0, "R6 bad sample");
        feed(3 * DECIM, 1, 8);
        check(1'b0, "R6 count cleared by bad");
        feed(DECIM, 1, 8);
        check(1'b1, "R6 relock after four");
    endtask

    task automatic t_boundary;
        feed(DECIM, 5, 0);
        check(1'b0, "R2 error WIN+1 is bad");
        feed(LOCK_N * DECIM, 4, 0);
        check(1'b1, "R2 error WIN is good");
        feed(DECIM, -6, 0);
        check(1'b0, "R1 fb leads by 6 bad");
        feed(LOCK_N * DECIM, -4, -1);
        check(1'b1, "R1 fb leads by 4 good");
    endtask

    task automatic t_powerdown;
        chip_en = 1'b0;
        check(1'b0, "R8 power down output low");
        pair(1);
        pair(1);
        chip_en = 1'b1;
        meas_idx = 0;
        check(1'b0, "R8 state cleared");
        feed(LOCK_N * DECIM - 1, 1, 1);
        check(1'b0, "R8 count restarted");
        feed(1, 1, 1);
        check(1'b1, "R8 relock after restart");
    endtask

    task automatic t_reset_locked;
        rst = 1'b1;
        check(1'b0, "R9 reset while locked");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        meas_idx = 0;
        feed(DECIM, 1, 1);
        check(1'b0, "R9 state cleared by reset");
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_enable();
        t_drop();
        t_run_clear();
        t_boundary();
        t_powerdown();
        t_reset_locked();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule